// File: doc/BRIEF.md
# Pixel Histogram and Cumulative Distribution Engine

This block builds the intensity histogram of a video frame. Every accepted pixel is a 10-bit value that selects one of 1024 bins held in a single 24-bit-wide on-chip memory. The selected bin is incremented through a read-modify-write pipeline that takes one pixel per clock. When the same value arrives on consecutive clocks, the pending result is forwarded, so no count is lost.

Once a frame has been counted, a cumulative pass rewrites the memory in place. The pass walks the bins in ascending order, so that each bin ends up holding the saturated sum of itself and every lower bin. In lookup mode the same memory becomes a transfer table: each incoming pixel value returns the stored word two clocks later. A flash-clear sweep zeroes the whole memory and the data-path registers, one word per clock. The block reports busy for the duration of both sweeps.

Top module: `hist_cdf_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy_o` and `out_valid_o` are 0 and `data_o` is 0.
- R2: With `mode_i` = 2'b01 (histogram), each pixel sampled with `pix_valid_i` high adds one to the bin whose index is `pix_i`.
- R3: Pixels with equal values on back-to-back clocks each add one. The forwarding also covers a lookup of a bin whose increment is still in flight.
- R4: A bin count stops at the all-ones value of `CNT_W` bits and never wraps.
- R5: A `start_i` pulse with `mode_i` = 2'b10 while the block is idle starts the cumulative pass. Bin k is replaced by the sum of old bins 0..k, and `busy_o` is high for exactly 1025 cycles.
- R6: The running sum of the cumulative pass saturates at the all-ones value of `CNT_W` bits.
- R7: With `mode_i` = 2'b11 (lookup), a pixel sampled at clock edge E gives `data_o` = stored word and `out_valid_o` = 1 after edge E+2, for one cycle only. Otherwise `data_o` holds its value.
- R8: A `clear_i` pulse while idle zeroes every bin and `data_o`, and `busy_o` is high for exactly 1024 cycles.
- R9: While `busy_o` is high, pixels, `start_i` and `clear_i` are ignored. Pixels with `mode_i` = 2'b00 are also ignored.
- R10: When `clear_i` and `start_i` arrive together, the clear is taken. A `start_i` pulse with `mode_i` other than 2'b10 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 none, 01 histogram, 10 cumulative pass, 11 lookup |
| start_i | input | 1 | Starts the cumulative pass |
| clear_i | input | 1 | Flash-clear request |
| pix_valid_i | input | 1 | Pixel qualifier |
| pix_i | input | PIX_W (10) | Pixel value / bin index |
| busy_o | output | 1 | Sweep in progress |
| out_valid_o | output | 1 | Lookup result valid |
| data_o | output | CNT_W (24) | Lookup result |

## Verification
Two functions can fall in the same cycle: the write-back of an incremented bin and the read of that same bin, whether by the next pixel or by a lookup. The stimulus table places equal pixel values on consecutive clocks and goes straight into lookup reads after the last increment. The lookup results are compared with counts kept by a software model. A long run of one value drives a bin into saturation, and a cumulative pass over it checks the saturating running sum.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_HIST = 2'b01,
    MODE_CDF  = 2'b10,
    MODE_LUT  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SW_IDLE,
    SW_CLEAR,
    SW_SUM,
    SW_DRAIN
  } sweep_e;
endpackage

// File: rtl/hist_bin_ram.sv
module hist_bin_ram #(
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // separate write and registered read: read returns the old word on collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hist_fwd_inc.sv
module hist_fwd_inc #(
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic [DW-1:0] rd_data,
  input  logic [AW-1:0] rd_addr,
  input  logic          lw_v,
  input  logic [AW-1:0] lw_addr,
  input  logic [DW-1:0] lw_data,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] inc_o
);
  localparam logic [DW-1:0] TOP = '1;

  // word written on the same edge the read was taken is newer than rd_data
  always_comb begin
    base_o = (lw_v && lw_addr == rd_addr) ? lw_data : rd_data;
    inc_o  = (base_o == TOP) ? TOP : base_o + DW'(1);
  end
endmodule

// File: rtl/hist_sweep_ctrl.sv
module hist_sweep_ctrl
  import hist_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_clr,
  input  logic          take_sum,
  output logic          busy_o,
  output logic          clr_we_o,
  output logic          sum_rd_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = '1;

  sweep_e        state;
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SW_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        SW_IDLE: begin
          cnt <= '0;
          if (take_clr)      state <= SW_CLEAR;
          else if (take_sum) state <= SW_SUM;
        end
        SW_CLEAR: begin
          cnt <= cnt + AW'(1);
          if (cnt == LAST) state <= SW_IDLE;
        end
        SW_SUM: begin
          cnt <= cnt + AW'(1);
          if (cnt == LAST) state <= SW_DRAIN;
        end
        SW_DRAIN: state <= SW_IDLE;
        default:  state <= SW_IDLE;
      endcase
    end
  end

  assign busy_o   = (state != SW_IDLE);
  assign clr_we_o = (state == SW_CLEAR);
  assign sum_rd_o = (state == SW_SUM);
  assign addr_o   = cnt;
endmodule

// File: rtl/hist_cdf_engine.sv
module hist_cdf_engine
  import hist_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             busy_o,
  output logic             out_valid_o,
  output logic [CNT_W-1:0] data_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  mode_e            mode;
  logic             sw_busy, clr_we, sum_rd;
  logic [PIX_W-1:0] sw_addr;
  logic             gate_ok, take_clr, take_sum, pix_take;

  logic             s1_v, s1_hist;
  logic [PIX_W-1:0] s1_addr;
  logic             c1_v;
  logic [PIX_W-1:0] c1_addr;
  logic             lw_v;
  logic [PIX_W-1:0] lw_addr;
  logic [CNT_W-1:0] lw_data;
  logic [CNT_W-1:0] run_sum, sum_next, rd_data, base, inc;
  logic [CNT_W:0]   sum_wide;

  logic             ram_we, ram_re;
  logic [PIX_W-1:0] ram_waddr, ram_raddr;
  logic [CNT_W-1:0] ram_wdata;

  assign mode     = mode_e'(mode_i);
  assign gate_ok  = !sw_busy && !s1_v;
  assign take_clr = clear_i && gate_ok;
  assign take_sum = start_i && (mode == MODE_CDF) && gate_ok && !clear_i;
  assign pix_take = pix_valid_i && !sw_busy && !take_clr && !take_sum &&
                    (mode == MODE_HIST || mode == MODE_LUT);

  hist_sweep_ctrl #(.AW(PIX_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .take_clr (take_clr),
    .take_sum (take_sum),
    .busy_o   (sw_busy),
    .clr_we_o (clr_we),
    .sum_rd_o (sum_rd),
    .addr_o   (sw_addr)
  );

  assign ram_re    = pix_take || sum_rd;
  assign ram_raddr = sum_rd ? sw_addr : pix_i;

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = s1_addr;
    ram_wdata = inc;
    if (clr_we) begin
      ram_we    = 1'b1;
      ram_waddr = sw_addr;
      ram_wdata = '0;
    end else if (c1_v) begin
      ram_we    = 1'b1;
      ram_waddr = c1_addr;
      ram_wdata = sum_next;
    end else if (s1_v && s1_hist) begin
      ram_we    = 1'b1;
    end
  end

  hist_bin_ram #(.AW(PIX_W), .DW(CNT_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (rd_data)
  );

  hist_fwd_inc #(.AW(PIX_W), .DW(CNT_W)) u_fwd (
    .rd_data (rd_data),
    .rd_addr (s1_addr),
    .lw_v    (lw_v),
    .lw_addr (lw_addr),
    .lw_data (lw_data),
    .base_o  (base),
    .inc_o   (inc)
  );

  assign sum_wide = {1'b0, run_sum} + {1'b0, rd_data};
  assign sum_next = sum_wide[CNT_W] ? CNT_TOP : sum_wide[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || take_clr) begin
      s1_v        <= 1'b0;
      s1_hist     <= 1'b0;
      s1_addr     <= '0;
      c1_v        <= 1'b0;
      c1_addr     <= '0;
      lw_v        <= 1'b0;
      lw_addr     <= '0;
      lw_data     <= '0;
      run_sum     <= '0;
      out_valid_o <= 1'b0;
      data_o      <= '0;
    end else begin
      s1_v        <= pix_take;
      s1_hist     <= (mode == MODE_HIST);
      s1_addr     <= pix_i;
      c1_v        <= sum_rd;
      c1_addr     <= sw_addr;
      lw_v        <= s1_v && s1_hist;
      lw_addr     <= s1_addr;
      lw_data     <= inc;
      if (take_sum)  run_sum <= '0;
      else if (c1_v) run_sum <= sum_next;
      out_valid_o <= s1_v && !s1_hist;
      if (s1_v && !s1_hist) data_o <= base;
    end
  end

  assign busy_o = sw_busy;
endmodule

// File: rtl/hist_cdf_chk.sv
module hist_cdf_chk #(
  parameter int PIX_W = 10,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_i,
  input logic             clear_i,
  input logic             pix_valid_i,
  input logic             busy_o,
  input logic             out_valid_o,
  input logic [CNT_W-1:0] data_o
);
  localparam int DEPTH = 1 << PIX_W;

  int run_len;

  always_ff @(posedge clk) begin
    if (rst)         run_len <= 0;
    else if (busy_o) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy_o && !out_valid_o && data_o == '0));

  assert_lut_origin_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> $past(pix_valid_i && mode_i == 2'b11, 2));

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!out_valid_o && !$rose(busy_o)) |-> $stable(data_o));

  assert_quiet_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !out_valid_o);

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_o) && $past(clear_i)) |-> (data_o == '0));

  // R5 and R8: a sweep lasts exactly one pass over the memory
  assert_sweep_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_len == DEPTH || run_len == DEPTH + 1));

  assert_sweep_bound_R8: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (run_len <= DEPTH + 1));
endmodule

bind hist_cdf_engine hist_cdf_chk #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_i      (mode_i),
  .clear_i     (clear_i),
  .pix_valid_i (pix_valid_i),
  .busy_o      (busy_o),
  .out_valid_o (out_valid_o),
  .data_o      (data_o)
);

// File: tb/tb_hist_cdf_engine.sv
module tb_hist_cdf_engine;
  localparam int PW   = 10;
  localparam int CW   = 12;
  localparam int NB   = 1 << PW;
  localparam int CMAX = (1 << CW) - 1;

  // {pixel, expected final count of that pixel}; equal values back to back
  localparam logic [21:0] HVEC [16] = '{
    {10'd5, 12'd5},   {10'd5, 12'd5},    {10'd5, 12'd5},    {10'd7, 12'd2},
    {10'd5, 12'd5},   {10'd1023, 12'd2}, {10'd1023, 12'd2}, {10'd0, 12'd1},
    {10'd9, 12'd4},   {10'd9, 12'd4},    {10'd9, 12'd4},    {10'd9, 12'd4},
    {10'd7, 12'd2},   {10'd300, 12'd2},  {10'd5, 12'd5},    {10'd300, 12'd2}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    mode_i;
  logic          start_i, clear_i, pix_valid_i;
  logic [PW-1:0] pix_i;
  logic          busy_o, out_valid_o;
  logic [CW-1:0] data_o;

  int  n_chk = 0;
  int  n_bad = 0;
  int  ref_cnt [NB];
  int  cdf_ref [NB];
  bit  done = 1'b0;

  always #10 clk = ~clk;

  hist_cdf_engine #(.PIX_W(PW), .CNT_W(CW)) dut (
    .clk (clk), .rst (rst), .mode_i (mode_i), .start_i (start_i),
    .clear_i (clear_i), .pix_valid_i (pix_valid_i), .pix_i (pix_i),
    .busy_o (busy_o), .out_valid_o (out_valid_o), .data_o (data_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic feed(input int p, input int m);
    @(negedge clk);
    mode_i = m[1:0]; pix_i = p[PW-1:0]; pix_valid_i = 1'b1;
  endtask

  task automatic lut_read(input int p, output int v, output int ov);
    @(negedge clk);
    mode_i = 2'b11; pix_i = p[PW-1:0]; pix_valid_i = 1'b1;
    @(negedge clk);
    pix_valid_i = 1'b0;
    @(negedge clk);
    v  = int'(data_o);
    ov = int'(out_valid_o);
  endtask

  task automatic pulse(input bit clr, input bit st, input int m, input bit poke,
                       output int len);
    @(negedge clk);
    pix_valid_i = 1'b0; clear_i = clr; start_i = st; mode_i = m[1:0];
    @(negedge clk);
    clear_i = 1'b0; start_i = 1'b0;
    len = 0;
    while (busy_o) begin
      len++;
      if (poke && len == 10) begin
        mode_i = 2'b01; pix_i = 10'd5; pix_valid_i = 1'b1; clear_i = 1'b1;
      end
      if (poke && len == 11) begin
        pix_valid_i = 1'b0; clear_i = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic build_cdf();
    int cum = 0;
    for (int k = 0; k < NB; k++) begin
      cum += ref_cnt[k];
      if (cum > CMAX) cum = CMAX;
      cdf_ref[k] = cum;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..R10 act=timeout exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int len, v, ov;
    rst = 1'b1; mode_i = 2'b00; start_i = 1'b0; clear_i = 1'b0;
    pix_valid_i = 1'b0; pix_i = '0;
    for (int k = 0; k < NB; k++) ref_cnt[k] = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 out_valid", int'(out_valid_o), 0);
    chk("R1 data", int'(data_o), 0);

    pulse(1'b1, 1'b0, 0, 1'b0, len);
    chk("R8 clear length", len, 1024);

    // stimulus table: histogram feed, one pixel per clock
    for (int i = 0; i < 16; i++) begin
      feed(int'(HVEC[i][21:12]), 1);
      ref_cnt[HVEC[i][21:12]]++;
    end
    feed(5, 0);  // R9: mode 00 pixel must not count
    @(negedge clk); pix_valid_i = 1'b0;

    // walk the table: lookup each pixel and compare with its expected count
    for (int i = 0; i < 16; i++) begin
      lut_read(int'(HVEC[i][21:12]), v, ov);
      chk("R2 R3 bin count", v, int'(HVEC[i][11:0]));
      chk("R7 out_valid", ov, 1);
    end
    @(negedge clk);
    chk("R7 single pulse", int'(out_valid_o), 0);
    lut_read(12, v, ov);
    chk("R2 untouched bin", v, 0);

    // back-to-back increment then immediate lookup of the same bin (R3)
    feed(40, 1); feed(40, 1); ref_cnt[40] += 2;
    lut_read(40, v, ov);
    chk("R3 forward to lookup", v, 2);

    // cumulative pass with ignored pixel and clear during busy (R9)
    pulse(1'b0, 1'b1, 2, 1'b1, len);
    chk("R5 R9 pass length", len, 1025);
    build_cdf();
    foreach (cdf_ref[k]) begin
      if (k == 0 || k == 4 || k == 5 || k == 7 || k == 9 || k == 40 ||
          k == 299 || k == 300 || k == 1022 || k == 1023) begin
        lut_read(k, v, ov);
        chk("R5 cumulative bin", v, cdf_ref[k]);
      end
    end

    pulse(1'b0, 1'b1, 3, 1'b0, len);
    chk("R10 start outside mode", len, 0);

    pulse(1'b1, 1'b0, 0, 1'b0, len);
    chk("R8 clear length", len, 1024);
    for (int k = 0; k < NB; k++) ref_cnt[k] = 0;
    lut_read(5, v, ov);
    chk("R8 bin zeroed", v, 0);
    lut_read(1023, v, ov);
    chk("R8 top bin zeroed", v, 0);

    // saturation of a bin count
    for (int i = 0; i < CMAX + 5; i++) feed(3, 1);
    for (int i = 0; i < 10; i++) feed(2, 1);
    ref_cnt[3] = CMAX; ref_cnt[2] = 10;
    lut_read(3, v, ov);
    chk("R4 saturated bin", v, CMAX);
    lut_read(2, v, ov);
    chk("R2 plain bin", v, 10);

    pulse(1'b0, 1'b1, 2, 1'b0, len);
    chk("R5 pass length", len, 1025);
    lut_read(1, v, ov);
    chk("R5 low bin", v, 0);
    lut_read(2, v, ov);
    chk("R5 first sum", v, 10);
    lut_read(3, v, ov);
    chk("R6 sum saturates", v, CMAX);
    lut_read(1023, v, ov);
    chk("R6 top sum", v, CMAX);

    // clear wins over start
    pulse(1'b1, 1'b1, 2, 1'b0, len);
    chk("R10 clear priority length", len, 1024);
    lut_read(3, v, ov);
    chk("R10 clear applied", v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule